// File: doc/BRIEF.md
# Dual-Issue Pairing Checker

This block sits between an in-order front end and two execution pipes. Each cycle the front end offers up to two decoded instructions: an older one on slot 0 and a younger one on slot 1. The block decides in the same cycle which of them may issue. The older instruction always goes to the primary pipe. The younger one joins it on the secondary pipe only if it reads no register the older one writes, and only if it needs a different kind of execution unit.

When the pair cannot go together, the younger instruction is kept in a one-entry holding register and the `hold` output is raised. On the next clock the held instruction becomes the older member of the pair. The front end's slot 0 then supplies its younger partner, and slot 1 is not consumed in that cycle. This keeps program order. A stall from downstream freezes the holding register and silences every strobe. Two counters report how many cycles issued a pair and how many issued a single instruction.

Top module: `dip_pair_issue`

## Requirements
- R1: Whenever `stall` is low and an older instruction is present, `issue_pri` is high in that same cycle. The older instruction is the held instruction if one exists, else slot 0 if valid, else slot 1.
- R2: The younger instruction is not paired if either of its two sources (packed as `{src1,src0}`, 3 bits each) equals the older destination while the older write-enable is 1. `hold` is raised instead.
- R3: When the older write-enable is 0, matching register indices do not prevent pairing.
- R4: Two instructions of the same unit class never pair. Class codes are 0 integer ALU, 1 floating point, 2 branch, 3 reserved, and code 3 is a class of its own.
- R5: When a valid pair is split, `hold` is 1. On the next non-stalled cycle the held instruction issues on the primary pipe with slot 0 as its younger partner. Slot 1 is ignored in that cycle.
- R6: With no held instruction and slot 0 invalid, a valid slot 1 issues on the primary pipe and `issue_sec` stays 0.
- R7: While `stall` is 1, `issue_pri`, `issue_sec` and `hold` are 0, and the held instruction and both counters keep their values.
- R8: `pair_cnt` rises by one after each cycle with `issue_sec` high. `single_cnt` rises by one after each cycle with only `issue_pri` high. Both counts wrap.
- R9: `issue_sec` is never high without `issue_pri`. It is high exactly when both instructions are valid and neither R2 nor R4 blocks them.
- R10: After reset, no instruction is held, both counters are 0, and with idle inputs all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| stall | input | 1 | Downstream stall; freezes the block |
| in0_vld | input | 1 | Slot 0 (older) valid |
| in0_dst | input | 3 | Slot 0 destination register |
| in0_srcs | input | 6 | Slot 0 source registers `{src1,src0}` |
| in0_unit | input | 2 | Slot 0 unit class |
| in0_we | input | 1 | Slot 0 writes its destination |
| in1_vld | input | 1 | Slot 1 (younger) valid |
| in1_dst | input | 3 | Slot 1 destination register |
| in1_srcs | input | 6 | Slot 1 source registers `{src1,src0}` |
| in1_unit | input | 2 | Slot 1 unit class |
| in1_we | input | 1 | Slot 1 writes its destination |
| issue_pri | output | 1 | Older instruction issues on the primary pipe |
| issue_sec | output | 1 | Younger instruction issues on the secondary pipe |
| hold | output | 1 | Younger instruction retained for the next cycle |
| pair_cnt | output | CNT_W | Count of paired-issue cycles |
| single_cnt | output | CNT_W | Count of single-issue cycles |

## Verification
`issue_pri`, `issue_sec` and `hold` are due in the same cycle as the inputs and the current held state. The holding register and both counters change at the next rising edge, so their effect shows one cycle after the stimulus. The bench applies inputs just after each falling edge and compares all five outputs against its model shortly before the next rising edge. It advances the model's held instruction and counts only at that rising edge, so every comparison uses the cycle in which a result is due.

// File: rtl/dip_pkg.sv
package dip_pkg;
  localparam int REG_W   = 3;
  localparam int NUM_SRC = 2;
  localparam int UNIT_W  = 2;
  localparam int SRCS_W  = NUM_SRC * REG_W;

  typedef enum logic [UNIT_W-1:0] {
    UC_ALU = 2'd0,
    UC_FPU = 2'd1,
    UC_BRN = 2'd2,
    UC_RSV = 2'd3
  } unit_e;

  typedef struct packed {
    logic              vld;
    logic [REG_W-1:0]  dst;
    logic [SRCS_W-1:0] srcs;
    unit_e             unit;
    logic              we;
  } slot_t;

  localparam slot_t SLOT_EMPTY = '{vld: 1'b0, dst: '0, srcs: '0, unit: UC_ALU, we: 1'b0};
endpackage

// File: rtl/dip_slot_mux.sv
module dip_slot_mux
  import dip_pkg::*;
(
  input  slot_t held,
  input  slot_t fe0,
  input  slot_t fe1,
  output slot_t older,
  output slot_t younger
);
  always_comb begin
    older   = SLOT_EMPTY;
    younger = SLOT_EMPTY;
    if (held.vld) begin
      older   = held;
      younger = fe0;
    end else if (fe0.vld) begin
      older   = fe0;
      younger = fe1;
    end else begin
      older   = fe1;
      younger = SLOT_EMPTY;
    end
  end
endmodule

// File: rtl/dip_hazard.sv
module dip_hazard
  import dip_pkg::*;
(
  input  slot_t older,
  input  slot_t younger,
  output logic  raw_hit,
  output logic  unit_clash,
  output logic  can_pair
);
  logic [NUM_SRC-1:0] src_match;
  logic               both_vld;

  assign both_vld = older.vld & younger.vld;

  for (genvar gi = 0; gi < NUM_SRC; gi++) begin : g_src
    assign src_match[gi] = (younger.srcs[gi*REG_W +: REG_W] == older.dst);
  end

  always_comb begin
    raw_hit    = both_vld & older.we & (|src_match);
    unit_clash = both_vld & (older.unit == younger.unit);
    can_pair   = both_vld & ~raw_hit & ~unit_clash;
  end
endmodule

// File: rtl/dip_tally.sv
module dip_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_pair,
  input  logic             inc_single,
  output logic [CNT_W-1:0] pair_cnt,
  output logic [CNT_W-1:0] single_cnt
);
  logic [CNT_W-1:0] pair_nxt, single_nxt;

  always_comb begin
    pair_nxt   = pair_cnt;
    single_nxt = single_cnt;
    if (inc_pair)   pair_nxt   = pair_cnt + 1'b1;
    if (inc_single) single_nxt = single_cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pair_cnt   <= '0;
      single_cnt <= '0;
    end else begin
      pair_cnt   <= pair_nxt;
      single_cnt <= single_nxt;
    end
  end

  a_r8_pair_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_pair |=> pair_cnt == $past(pair_cnt) + 1'b1);
  a_r8_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_single |=> single_cnt == $past(single_cnt) + 1'b1);
  a_r8_pair_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_pair |=> $stable(pair_cnt));
endmodule

// File: rtl/dip_pair_issue.sv
module dip_pair_issue
  import dip_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      stall,
  input  logic                      in0_vld,
  input  logic [dip_pkg::REG_W-1:0]  in0_dst,
  input  logic [dip_pkg::SRCS_W-1:0] in0_srcs,
  input  logic [dip_pkg::UNIT_W-1:0] in0_unit,
  input  logic                      in0_we,
  input  logic                      in1_vld,
  input  logic [dip_pkg::REG_W-1:0]  in1_dst,
  input  logic [dip_pkg::SRCS_W-1:0] in1_srcs,
  input  logic [dip_pkg::UNIT_W-1:0] in1_unit,
  input  logic                      in1_we,
  output logic                      issue_pri,
  output logic                      issue_sec,
  output logic                      hold,
  output logic [CNT_W-1:0]          pair_cnt,
  output logic [CNT_W-1:0]          single_cnt
);
  slot_t fe0, fe1, older, younger;
  slot_t held_q, held_nxt;
  logic  raw_hit, unit_clash, can_pair;
  logic  held_en;

  always_comb begin
    fe0 = '{vld: in0_vld, dst: in0_dst, srcs: in0_srcs, unit: unit_e'(in0_unit), we: in0_we};
    fe1 = '{vld: in1_vld, dst: in1_dst, srcs: in1_srcs, unit: unit_e'(in1_unit), we: in1_we};
  end

  dip_slot_mux u_mux (
    .held    (held_q),
    .fe0     (fe0),
    .fe1     (fe1),
    .older   (older),
    .younger (younger)
  );

  dip_hazard u_haz (
    .older      (older),
    .younger    (younger),
    .raw_hit    (raw_hit),
    .unit_clash (unit_clash),
    .can_pair   (can_pair)
  );

  always_comb begin
    issue_pri = ~stall & older.vld;
    issue_sec = ~stall & can_pair;
    hold      = ~stall & older.vld & younger.vld & (raw_hit | unit_clash);
  end

  // next state of the one-entry holding register
  always_comb begin
    held_en  = ~stall;
    held_nxt = hold ? younger : SLOT_EMPTY;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= SLOT_EMPTY;
    else if (held_en) held_q <= held_nxt;
  end

  dip_tally #(.CNT_W(CNT_W)) u_tally (
    .clk        (clk),
    .rst_n      (rst_n),
    .inc_pair   (issue_sec),
    .inc_single (issue_pri & ~issue_sec),
    .pair_cnt   (pair_cnt),
    .single_cnt (single_cnt)
  );

  a_r9_sec_needs_pri: assert property (@(posedge clk) disable iff (!rst_n)
    issue_sec |-> issue_pri);
  a_r7_stall_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (!issue_pri && !issue_sec && !hold));
  a_r7_stall_keeps_slot: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(held_q));
  a_r5_held_goes_first: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> (stall || issue_pri));
  a_r6_lone_younger: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !held_q.vld && !in0_vld && in1_vld) |-> (issue_pri && !issue_sec));
  a_r1_pri_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && (in0_vld || in1_vld)) |-> issue_pri);
endmodule

// File: tb/dip_pair_issue_bench.sv
module dip_pair_issue_bench;
  localparam int CW = 16;
  localparam int CLK_HALF = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic stall;
  logic in0_vld, in0_we, in1_vld, in1_we;
  logic [2:0] in0_dst, in1_dst;
  logic [5:0] in0_srcs, in1_srcs;
  logic [1:0] in0_unit, in1_unit;
  logic issue_pri, issue_sec, hold;
  logic [CW-1:0] pair_cnt, single_cnt;

  int checks = 0;
  int fails  = 0;

  // reference model state
  bit m_vld, m_we;
  int m_dst, m_s0, m_s1, m_unit;
  int m_pairs = 0, m_singles = 0;

  always #(CLK_HALF) clk = ~clk;

  dip_pair_issue #(.CNT_W(CW)) u_dip_pair_issue (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .in0_vld(in0_vld), .in0_dst(in0_dst), .in0_srcs(in0_srcs), .in0_unit(in0_unit), .in0_we(in0_we),
    .in1_vld(in1_vld), .in1_dst(in1_dst), .in1_srcs(in1_srcs), .in1_unit(in1_unit), .in1_we(in1_we),
    .issue_pri(issue_pri), .issue_sec(issue_sec), .hold(hold),
    .pair_cnt(pair_cnt), .single_cnt(single_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic put0(input bit v, input int d, input int s0, input int s1, input int u, input bit we);
    in0_vld = v; in0_dst = 3'(d); in0_srcs = {3'(s1), 3'(s0)}; in0_unit = 2'(u); in0_we = we;
  endtask

  task automatic put1(input bit v, input int d, input int s0, input int s1, input int u, input bit we);
    in1_vld = v; in1_dst = 3'(d); in1_srcs = {3'(s1), 3'(s0)}; in1_unit = 2'(u); in1_we = we;
  endtask

  // one cycle: inputs already applied after a falling edge
  task automatic step(input string req);
    bit ov, yv, owe, ywe, dep, same, ep, es, eh;
    int od, ou, yd, ys0, ys1, yu;
    #1;
    ov = 0; yv = 0; owe = 0; ywe = 0; od = 0; ou = 0; yd = 0; ys0 = 0; ys1 = 0; yu = 0;
    if (m_vld) begin
      ov = 1; od = m_dst; ou = m_unit; owe = m_we;
      yv = in0_vld; yd = in0_dst; ys0 = in0_srcs[2:0]; ys1 = in0_srcs[5:3]; yu = in0_unit; ywe = in0_we;
    end else if (in0_vld) begin
      ov = 1; od = in0_dst; ou = in0_unit; owe = in0_we;
      yv = in1_vld; yd = in1_dst; ys0 = in1_srcs[2:0]; ys1 = in1_srcs[5:3]; yu = in1_unit; ywe = in1_we;
    end else if (in1_vld) begin
      ov = 1; od = in1_dst; ou = in1_unit; owe = in1_we;
    end
    dep  = ov && yv && owe && (ys0 == od || ys1 == od);
    same = ov && yv && (ou == yu);
    ep = !stall && ov;
    es = !stall && ov && yv && !dep && !same;
    eh = !stall && ov && yv && (dep || same);
    chk(req, "issue_pri", int'(issue_pri), int'(ep));
    chk(req, "issue_sec", int'(issue_sec), int'(es));
    chk(req, "hold", int'(hold), int'(eh));
    chk("R8", "pair_cnt", int'(pair_cnt), m_pairs % (1 << CW));
    chk("R8", "single_cnt", int'(single_cnt), m_singles % (1 << CW));
    @(posedge clk);
    if (!stall) begin
      if (es) m_pairs++;
      else if (ep) m_singles++;
      m_vld = eh;
      if (eh) begin
        m_dst = yd; m_s0 = ys0; m_s1 = ys1; m_unit = yu; m_we = ywe;
      end
    end
    @(negedge clk);
  endtask

  initial begin
    #(CLK_HALF * 2 * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  %0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    m_vld = 0; m_we = 0; m_dst = 0; m_s0 = 0; m_s1 = 0; m_unit = 0;
    rst_n = 0; stall = 0;
    put0(0, 0, 0, 0, 0, 0);
    put1(0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10", "issue_pri", int'(issue_pri), 0);
    chk("R10", "issue_sec", int'(issue_sec), 0);
    chk("R10", "hold", int'(hold), 0);
    chk("R10", "pair_cnt", int'(pair_cnt), 0);
    chk("R10", "single_cnt", int'(single_cnt), 0);
    rst_n = 1;
    @(negedge clk);
    step("R10");

    // R9 independent ALU + FPU pair
    put0(1, 1, 2, 3, 0, 1); put1(1, 4, 5, 6, 1, 1); step("R9");
    // R1 lone older on slot 0
    put0(1, 2, 0, 0, 2, 1); put1(0, 0, 0, 0, 0, 0); step("R1");
    // R2 read-after-write on src0, then held instr issues; slot 1 junk ignored (R5)
    put0(1, 3, 0, 0, 0, 1); put1(1, 5, 3, 1, 1, 0); step("R2");
    put0(1, 6, 0, 0, 2, 0); put1(1, 5, 5, 5, 1, 1); step("R5");
    // R2 hazard on src1
    put0(1, 7, 1, 1, 1, 1); put1(1, 0, 2, 7, 2, 1); step("R2");
    put0(0, 0, 0, 0, 0, 0); put1(1, 1, 1, 1, 2, 1); step("R5");
    // R3 no write-enable, same regs pair
    put0(1, 3, 0, 0, 0, 0); put1(1, 2, 3, 3, 1, 1); step("R3");
    // R4 same class, including reserved class 3
    put0(1, 1, 0, 0, 1, 1); put1(1, 2, 4, 4, 1, 1); step("R4");
    put0(1, 4, 0, 0, 3, 1); put1(0, 0, 0, 0, 0, 0); step("R4");
    put0(1, 5, 0, 0, 3, 1); put1(1, 6, 0, 0, 3, 1); step("R4");
    // R7 stall with held instruction pending, then release
    put0(1, 2, 0, 0, 0, 1); put1(1, 3, 1, 1, 1, 1); stall = 1; step("R7");
    stall = 1; step("R7");
    stall = 0; put0(1, 4, 4, 4, 0, 1); put1(0, 0, 0, 0, 0, 0); step("R5");
    // R6 slot 0 empty, slot 1 alone
    put0(0, 0, 0, 0, 0, 0); put1(1, 2, 2, 2, 0, 1); step("R6");
    put0(0, 0, 0, 0, 0, 0); put1(0, 0, 0, 0, 0, 0); step("R1");

    // mixed traffic with repeating hazards and stalls
    for (int i = 0; i < 3000; i++) begin
      stall = (($urandom % 8) == 0);
      put0(($urandom % 5) != 0, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 2);
      put1(($urandom % 4) != 0, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 4, $urandom % 2);
      step("R9");
    end
    stall = 0;
    put0(0, 0, 0, 0, 0, 0); put1(0, 0, 0, 0, 0, 0);
    step("R8");

    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule